// File: doc/BRIEF.md
# Acknowledge-Polling Bus Master Sequencer

This block is the master-side sequencer used after a write to a two-wire serial memory. The memory ignores the bus while its internal write cycle runs, so the sequencer keeps probing it. Each probe is a START condition followed by the device address with the direction bit set to write. The sequencer then releases SDA for the ninth clock and reads back the acknowledge. A missing acknowledge means the memory is still busy: the sequencer counts the miss, sends STOP and probes again at once.

Once the memory acknowledges, the sequencer branches on the operation that the host declared when it made the request. For a write it stays on the bus and clocks out the byte address right away, with no STOP in between, and leaves SCL low for the data phase that follows. For a read it closes the probe with STOP and leaves the bus idle. If the configured number of probes all go unanswered, it stops, raises a timeout flag and reports completion.

SCL is driven directly. SDA is open-drain: the block only asserts a pull-low enable and reads the line back. Every quarter of a bit period lasts a parameterised number of clock cycles.

Top module: `ackpoll_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, scl_o is 1, sda_oe is 0, and busy, done, timeout and retries are all 0.
- R2: A bit slot is four quarters of DIV cycles each. In the first two quarters scl_o is 0, and in the last two it is 1. For a data bit, sda_oe is the inverse of that bit for the whole slot.
- R3: Each probe has three parts. The first is a START: two quarters with scl_o 1 and sda_oe 0, then two quarters with scl_o 1 and sda_oe 1. Next come the eight bits {SLAVE_ADDR, 0}, most significant bit first. Last is a ninth slot with sda_oe 0.
- R4: sda_i is sampled on the clock edge where scl_o rises in the ninth slot, and a low value counts as an acknowledge. If sda_i is high there, retries increments on that same edge. The block then sends a STOP and, if probes remain, starts the next probe directly after it.
- R5: A STOP is four quarters with (scl_o, sda_oe) equal to (0,1), (1,1), (1,0) and (1,0).
- R6: If a probe is acknowledged and next_is_write was 1, no STOP follows. The block sends the eight bits of byte_addr, most significant bit first, then a ninth slot with sda_oe 0. It then finishes with scl_o 0 and sda_oe 0.
- R7: If a probe is acknowledged and next_is_write was 0, a STOP follows and the block finishes with scl_o 1 and sda_oe 0.
- R8: If MAX_ATTEMPTS probes in a row go unacknowledged, the block sends a STOP and finishes with timeout 1 and retries equal to MAX_ATTEMPTS. No further probe is made.
- R9: start_poll, next_is_write and byte_addr are taken only on a clock edge where busy is 0. While busy is 1, changes on them have no effect on any output.
- R10: done is a single-cycle pulse on the cycle where busy falls. retries and timeout hold their values until the next request is taken, which clears them.
- R11: While scl_o stays 1, sda_oe changes only inside a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_poll | input | 1 | Request a polling sequence (taken when idle) |
| next_is_write | input | 1 | Pending operation after acknowledge: 1 write, 0 read |
| byte_addr | input | 8 | Memory byte address sent when the pending operation is a write |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | SDA pull-low enable (1 drives the line low) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last sequence ended without any acknowledge |
| retries | output | $clog2(MAX_ATTEMPTS+1) | Unacknowledged probes in the last or current sequence |

## Verification
The memory model in the bench answers after a chosen number of silent probes. The main flow is run with zero, one and two misses. The write and read branches each run with an immediate answer and with a delayed one. Together these cases separate the in-place byte-address continuation from the STOP-then-release path, and they show that the miss counter and the STOP/restart spacing are correct. A memory that never answers exposes off-by-one faults in the probe limit. A run with start_poll, next_is_write and byte_addr toggled in mid-sequence shows that requests are latched only while idle.

// File: rtl/ackpoll_pkg.sv
// Shared types of the acknowledge-polling sequencer.
// Assumes nothing beyond the 1800-2017 language.
package ackpoll_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_SADDR = 3'd2,
        S_SACK  = 3'd3,
        S_BADDR = 3'd4,
        S_BACK  = 3'd5,
        S_STOP  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/ackpoll_tick.sv
// Quarter-bit timebase. Produces a one-cycle tick every DIV cycles while run is high.
// The counter restarts from zero whenever run is low.
// Assumes DIV >= 2.
module ackpoll_tick #(
    parameter int DIV = 8,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    // Count cycles within a quarter; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ackpoll_ctl.sv
// Polling control. Steps through START, address, acknowledge, byte address and STOP
// one quarter per tick, and keeps count of unanswered probes.
// Assumes tick is a single-cycle pulse and sda_i is already synchronised.
module ackpoll_ctl
    import ackpoll_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR   = 7'h50,
    parameter int         MAX_ATTEMPTS = 8,
    localparam int        RW           = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_poll,
    input  logic          next_is_write,
    input  logic [7:0]    byte_addr,
    input  logic          sda_i,
    output seq_state_e    state_o,
    output logic [1:0]    phase_o,
    output logic          bit_o,
    output logic          rest_low_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [RW-1:0] retries_o
);

    seq_state_e    state_q;
    logic [1:0]    phase_q;
    logic [2:0]    bitn_q;
    logic [7:0]    sh_q;
    logic [7:0]    addr_q;
    logic          wr_q;
    logic          ack_q;
    logic          again_q;
    logic          tmo_pend_q;
    logic          rest_low_q;
    logic          done_q;
    logic          timeout_q;
    logic [RW-1:0] retry_q;
    logic          last_q;

    assign last_q = (phase_q == 2'd3);

    // Sequence state, bit shifting, acknowledge sampling and retry accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            phase_q    <= '0;
            bitn_q     <= '0;
            sh_q       <= '0;
            addr_q     <= '0;
            wr_q       <= 1'b0;
            ack_q      <= 1'b0;
            again_q    <= 1'b0;
            tmo_pend_q <= 1'b0;
            rest_low_q <= 1'b0;
            done_q     <= 1'b0;
            timeout_q  <= 1'b0;
            retry_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE) begin
                if (start_poll) begin
                    state_q    <= S_START;
                    phase_q    <= '0;
                    retry_q    <= '0;
                    timeout_q  <= 1'b0;
                    wr_q       <= next_is_write;
                    addr_q     <= byte_addr;
                    again_q    <= 1'b0;
                    tmo_pend_q <= 1'b0;
                end
            end else if (tick) begin
                phase_q <= phase_q + 2'd1;
                case (state_q)
                    S_START: begin
                        if (last_q) begin
                            state_q <= S_SADDR;
                            bitn_q  <= 3'd7;
                            sh_q    <= {SLAVE_ADDR, 1'b0};
                        end
                    end
                    S_SADDR, S_BADDR: begin
                        if (last_q) begin
                            if (bitn_q == 3'd0) begin
                                state_q <= (state_q == S_SADDR) ? S_SACK : S_BACK;
                            end else begin
                                bitn_q <= bitn_q - 3'd1;
                                sh_q   <= {sh_q[6:0], 1'b0};
                            end
                        end
                    end
                    S_SACK: begin
                        if (phase_q == 2'd1) begin
                            ack_q <= !sda_i;
                            if (sda_i) begin
                                retry_q <= retry_q + RW'(1);
                            end
                        end
                        if (last_q) begin
                            if (ack_q && wr_q) begin
                                state_q <= S_BADDR;
                                bitn_q  <= 3'd7;
                                sh_q    <= addr_q;
                            end else begin
                                state_q <= S_STOP;
                                if (ack_q) begin
                                    again_q <= 1'b0;
                                end else if (retry_q == RW'(MAX_ATTEMPTS)) begin
                                    again_q    <= 1'b0;
                                    tmo_pend_q <= 1'b1;
                                end else begin
                                    again_q <= 1'b1;
                                end
                            end
                        end
                    end
                    S_BACK: begin
                        if (last_q) begin
                            state_q    <= S_IDLE;
                            done_q     <= 1'b1;
                            rest_low_q <= 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (last_q) begin
                            if (again_q) begin
                                state_q <= S_START;
                            end else begin
                                state_q    <= S_IDLE;
                                done_q     <= 1'b1;
                                timeout_q  <= tmo_pend_q;
                                rest_low_q <= 1'b0;
                            end
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign state_o    = state_q;
    assign phase_o    = phase_q;
    assign bit_o      = sh_q[7];
    assign rest_low_o = rest_low_q;
    assign done_o     = done_q;
    assign timeout_o  = timeout_q;
    assign retries_o  = retry_q;

    // R10: completion is a single pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: the miss counter never passes the probe limit
    a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RW'(MAX_ATTEMPTS));

    // R8: timeout only after the full number of misses
    a_r8_timeout_full: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_q |-> (retry_q == RW'(MAX_ATTEMPTS)));

    // R9: request fields stay frozen while a sequence runs
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(wr_q) && $stable(addr_q)));

endmodule

// File: rtl/ackpoll_pins.sv
// Pin encoder. Maps the sequence state, quarter and current bit onto SCL and the
// SDA pull-low enable. Purely combinational; its inputs are all registers.
module ackpoll_pins
    import ackpoll_pkg::*;
(
    input  seq_state_e state,
    input  logic [1:0] phase,
    input  logic       bit_val,
    input  logic       rest_low,
    output logic       scl,
    output logic       sda_pull
);

    // Pin levels per step of the sequence.
    always_comb begin
        scl      = 1'b1;
        sda_pull = 1'b0;
        case (state)
            S_IDLE:  scl = !rest_low;
            S_START: sda_pull = phase[1];
            S_SADDR, S_BADDR: begin
                scl      = phase[1];
                sda_pull = !bit_val;
            end
            S_SACK, S_BACK: scl = phase[1];
            S_STOP: begin
                scl      = (phase != 2'd0);
                sda_pull = !phase[1];
            end
            default: begin
                scl      = 1'b1;
                sda_pull = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ackpoll_seq.sv
// Acknowledge-polling bus master sequencer, top level.
// Wires the quarter timebase, the polling control and the pin encoder.
// Assumes sda_i is synchronised to clk and reflects the wired-AND bus level.
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int         DIV          = 8,
    parameter logic [6:0] SLAVE_ADDR   = 7'h50,
    parameter int         MAX_ATTEMPTS = 8,
    localparam int        RW           = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_poll,
    input  logic          next_is_write,
    input  logic [7:0]    byte_addr,
    input  logic          sda_i,
    output logic          scl_o,
    output logic          sda_oe,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [RW-1:0] retries
);

    seq_state_e st;
    logic [1:0] phase;
    logic       bit_val;
    logic       rest_low;
    logic       tick;

    assign busy = (st != S_IDLE);

    ackpoll_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ackpoll_ctl #(.SLAVE_ADDR(SLAVE_ADDR), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .start_poll    (start_poll),
        .next_is_write (next_is_write),
        .byte_addr     (byte_addr),
        .sda_i         (sda_i),
        .state_o       (st),
        .phase_o       (phase),
        .bit_o         (bit_val),
        .rest_low_o    (rest_low),
        .done_o        (done),
        .timeout_o     (timeout),
        .retries_o     (retries)
    );

    ackpoll_pins u_pins (
        .state    (st),
        .phase    (phase),
        .bit_val  (bit_val),
        .rest_low (rest_low),
        .scl      (scl_o),
        .sda_pull (sda_oe)
    );

    // R11: SDA moves under a high SCL only for START or STOP
    a_r11_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_oe != $past(sda_oe))) |->
            (st == S_START || st == S_STOP));

    // R10: done coincides with the end of busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/ackpoll_seq_tb.sv
// Bench: behavioural phase-list model of the polling sequence, compared every clock.
module ackpoll_seq_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         DIV        = 4;
    localparam logic [6:0] SADDR      = 7'h50;
    localparam int         MAXA       = 4;
    localparam int         RW         = $clog2(MAXA + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_poll = 1'b0;
    logic          next_is_write = 1'b0;
    logic [7:0]    byte_addr = 8'h00;
    logic          sda_i;
    logic          scl_o, sda_oe, busy, done, timeout;
    logic [RW-1:0] retries;

    ackpoll_seq #(.DIV(DIV), .SLAVE_ADDR(SADDR), .MAX_ATTEMPTS(MAXA)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_poll(start_poll), .next_is_write(next_is_write),
        .byte_addr(byte_addr), .sda_i(sda_i), .scl_o(scl_o), .sda_oe(sda_oe),
        .busy(busy), .done(done), .timeout(timeout), .retries(retries)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model state
    bit q_scl[$], q_oe[$], q_pull[$], q_inc[$];
    logic m_scl, m_oe, m_pull, m_busy, m_done, m_tmo;
    int   m_retry, m_cnt;
    logic rest_scl, plan_tmo;
    int   plan_fails;
    int   nvec = 0, nbad = 0;
    string tag = "R1";
    bit   checking = 1'b0;

    assign sda_i = !(sda_oe || m_pull);

    task automatic push(input bit s, input bit o, input bit p, input bit i);
        q_scl.push_back(s); q_oe.push_back(o); q_pull.push_back(p); q_inc.push_back(i);
    endtask
    task automatic push_start();
        push(1, 0, 0, 0); push(1, 0, 0, 0); push(1, 1, 0, 0); push(1, 1, 0, 0);
    endtask
    task automatic push_bit(input bit b);
        push(0, !b, 0, 0); push(0, !b, 0, 0); push(1, !b, 0, 0); push(1, !b, 0, 0);
    endtask
    task automatic push_ack(input bit p, input bit inc);
        push(0, 0, p, 0); push(0, 0, p, 0); push(1, 0, p, inc); push(1, 0, p, 0);
    endtask
    task automatic push_stop();
        push(0, 1, 0, 0); push(1, 1, 0, 0); push(1, 0, 0, 0); push(1, 0, 0, 0);
    endtask

    // Build the expected phase list for one request.
    task automatic build(input bit wr, input logic [7:0] ba);
        logic [7:0] sa;
        sa = {SADDR, 1'b0};
        plan_tmo = 1'b0;
        for (int a = 0; a < MAXA; a++) begin
            push_start();
            for (int i = 7; i >= 0; i--) push_bit(sa[i]);
            if (a < plan_fails) begin
                push_ack(0, 1);
                push_stop();
                rest_scl = 1'b1;
                if (a == MAXA - 1) plan_tmo = 1'b1;
            end else begin
                push_ack(1, 0);
                if (wr) begin
                    for (int i = 7; i >= 0; i--) push_bit(ba[i]);
                    push_ack(1, 0);
                    rest_scl = 1'b0;
                end else begin
                    push_stop();
                    rest_scl = 1'b1;
                end
                break;
            end
        end
    endtask

    task automatic load_front();
        m_scl = q_scl[0]; m_oe = q_oe[0]; m_pull = q_pull[0];
        if (q_inc[0]) m_retry++;
    endtask

    // Model advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_scl.delete(); q_oe.delete(); q_pull.delete(); q_inc.delete();
            m_scl = 1; m_oe = 0; m_pull = 0; m_busy = 0; m_done = 0;
            m_tmo = 0; m_retry = 0; m_cnt = 0; rest_scl = 1;
        end else if (m_busy) begin
            m_done = 0;
            m_cnt++;
            if (m_cnt == DIV) begin
                m_cnt = 0;
                void'(q_scl.pop_front()); void'(q_oe.pop_front());
                void'(q_pull.pop_front()); void'(q_inc.pop_front());
                if (q_scl.size() == 0) begin
                    m_busy = 0; m_done = 1; m_scl = rest_scl; m_oe = 0; m_pull = 0;
                    m_tmo = plan_tmo;
                end else begin
                    load_front();
                end
            end
        end else begin
            m_done = 0;
            if (start_poll) begin
                build(next_is_write, byte_addr);
                m_busy = 1; m_retry = 0; m_tmo = 0; m_cnt = 0;
                load_front();
            end
        end
    end

    task automatic cmp1(input string what, input int act, input int exp);
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            int bad0;
            bad0 = nbad;
            nvec++;
            cmp1("scl_o", int'(scl_o), int'(m_scl));
            cmp1("sda_oe", int'(sda_oe), int'(m_oe));
            cmp1("busy", int'(busy), int'(m_busy));
            cmp1("done", int'(done), int'(m_done));
            cmp1("timeout", int'(timeout), int'(m_tmo));
            cmp1("retries", int'(retries), m_retry);
            if (nbad > bad0) nbad = bad0 + 1;
        end
    end

    task automatic run_req(input int fails, input bit wr, input logic [7:0] ba,
                           input bit disturb, input string t);
        tag = t;
        plan_fails = fails;
        @(negedge clk);
        start_poll = 1; next_is_write = wr; byte_addr = ba;
        @(negedge clk);
        start_poll = 0;
        if (disturb) begin
            repeat (50) @(negedge clk);
            start_poll = 1; next_is_write = !wr; byte_addr = ~ba;
            repeat (3) @(negedge clk);
            start_poll = 0;
        end
        while (m_busy) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        nvec++;
        if (scl_o !== 1'b1 || sda_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0 ||
            timeout !== 1'b0 || retries !== '0) begin
            nbad++;
            $display("FAIL R1 reset: actual scl=%b oe=%b busy=%b done=%b to=%b r=%0d expected 1 0 0 0 0 0",
                     scl_o, sda_oe, busy, done, timeout, retries);
        end
        rst_n = 1;
        checking = 1;
        run_req(0, 1, 8'hA5, 0, "R2 R3 R4 R6");
        run_req(2, 0, 8'h00, 0, "R4 R5 R7");
        run_req(1, 1, 8'h3C, 1, "R9 R6 R11");
        run_req(MAXA + 2, 0, 8'h11, 0, "R8 R10");
        run_req(0, 0, 8'hFF, 0, "R7 R10 R11");
        run_req(3, 1, 8'h81, 0, "R4 R6 R2");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule